// File: doc/BRIEF.md
# Interrupt Output Controller with Holdoff

This block merges a vector of interrupt status bits with a matching vector of enable bits into one master interrupt and drives an external interrupt pin from it. The pin can act as a push-pull driver with either polarity, or as an open-drain driver for a wired-OR line. In open-drain mode the polarity setting is ignored, the pin is pulled low only while asserted and is released otherwise. Its outputs are a pin data value and an output enable, so the pad can model both buffer types.

A programmable holdoff keeps the pin quiet for a minimum time after each interrupt pulse ends. The time is given in ticks of 10 microseconds, derived from the system clock by a parameterised prescaler. Software can restart a running holdoff, or switch it off by writing a zero interval; an interrupt that was held back then reaches the pin at once. A power-management wake input reaches the pin directly and is never held back. All settings and status sit in one 32-bit word, written and read through a selected register port.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the register word reads 0x00000000 and `irq_oe` is 0 (open-drain, released).
- R2: Bit 12 of the read word is 1 exactly when some `int_sts` bit and its `int_en` bit are both 1, whatever the pin enable and the holdoff state.
- R3: While the pin enable (bit 8) is 0, the pin is deasserted one cycle later and stays so, and bit 12 still follows the sources.
- R4: With bit 0 = 1 (push-pull), `irq_oe` is 1 and `irq_o` equals the asserted state when bit 4 = 1 (active high), or its inverse when bit 4 = 0 (active low). The pin follows its inputs one clock later.
- R5: With bit 0 = 0 (open-drain), `irq_o` is 0 and `irq_oe` is 1 only while asserted, whatever bit 4 holds.
- R6: When the interrupt carried by the sources falls from asserted to deasserted at the pin and the interval (bits 31:24) is N > 0, bit 13 reads 1 for N×TICK_DIV cycles. Throughout that time the enabled sources do not assert the pin.
- R7: An interrupt that was held back by the holdoff asserts the pin one cycle after bit 13 returns to 0.
- R8: Writing an interval of 0 ends a running holdoff at once (bit 13 reads 0 after the write), and a pending interrupt asserts the pin one cycle later.
- R9: A write with bit 14 = 1 and a non-zero interval starts a fresh full interval, even while one is running. Bit 14 always reads 0.
- R10: Writing a new non-zero interval does not change the length of a holdoff already running.
- R11: The wake input `pme_irq` asserts the pin one cycle later whenever the pin enable is 1, even during a holdoff.
- R12: Written fields (interval, enable, polarity, type) read back. Reserved bits 23:15, 11:9, 7:5 and 3:1 read 0. `reg_rdata` is 0 and writes are ignored while `reg_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Selects the configuration word |
| reg_we | input | 1 | Write strobe, used with reg_sel |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (0 when not selected) |
| int_sts | input | NUM_SRC | Interrupt source status bits |
| int_en | input | NUM_SRC | Per-source enables |
| pme_irq | input | 1 | Wake interrupt, bypasses the holdoff |
| irq_o | output | 1 | Pin data value |
| irq_oe | output | 1 | Pin output enable |

## Verification
Two events can land in one cycle. The first is the fall of the source interrupt, which would start a holdoff. The second is a register write that restarts the holdoff, changes its interval or disables it. The bench provokes these by writing in the cycle next to each source drop and by writing while a holdoff is running with a source still pending. A behavioural model tracks the remaining holdoff as a cycle count, gives a zero-interval write priority over any start, and compares the pin and the read word in every cycle.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int WORD_W   = 32;
  localparam int INTV_W   = 8;
  localparam int INTV_LSB = 24;
  localparam int CLR_BIT  = 14;
  localparam int HOLD_BIT = 13;
  localparam int MST_BIT  = 12;
  localparam int EN_BIT   = 8;
  localparam int POL_BIT  = 4;
  localparam int TYPE_BIT = 0;

  typedef struct packed {
    logic [INTV_W-1:0] intv;
    logic              pin_en;
    logic              pol_high;
    logic              push_pull;
  } pin_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pin_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [WORD_W-1:0]      wdata_i,
  output pin_cfg_t               cfg_o,
  output logic [INTV_W-1:0]      intv_nxt_o,
  output logic                   restart_o
);
  pin_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      cfg_d.intv      = wdata_i[INTV_LSB +: INTV_W];
      cfg_d.pin_en    = wdata_i[EN_BIT];
      cfg_d.pol_high  = wdata_i[POL_BIT];
      cfg_d.push_pull = wdata_i[TYPE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign intv_nxt_o = cfg_d.intv;
  assign restart_o  = wr_i & wdata_i[CLR_BIT];

  // R12: a write lands in the stored fields on the next cycle
  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cfg_q.intv == $past(wdata_i[INTV_LSB +: INTV_W])));
endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
  parameter int TICK_DIV = 1000,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] intv_nxt_i,
  input  logic             start_req_i,
  output logic             active_o
);
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;
  logic             off_w, start_w;

  assign off_w   = (intv_nxt_i == '0);
  assign start_w = start_req_i & ~off_w;

  generate
    if (TICK_DIV <= 1) begin : g_no_presc
      assign tick = 1'b1;
    end else begin : g_presc
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] presc_q, presc_d;

      always_comb begin
        presc_d = presc_q;
        if (off_w || start_w || !active_q) presc_d = '0;
        else if (presc_q == LAST)          presc_d = '0;
        else                               presc_d = presc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
      end

      assign tick = (presc_q == LAST);

      // R6: prescaler never passes its last state
      p_presc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q <= LAST);
    end
  endgenerate

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (off_w) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (start_w) begin
      active_d = 1'b1;
      cnt_d    = intv_nxt_i;
    end else if (active_q && tick) begin
      if (cnt_q <= 1) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

  // R6: a holdoff only begins after a start request with a live interval
  p_rise_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> ($past(start_req_i) && ($past(intv_nxt_i) != '0)));

  // R8: a zero interval ends the holdoff on the next cycle
  p_zero_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_nxt_i == '0) |=> !active_q);
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic master_i,
  input  logic pme_i,
  input  logic pin_en_i,
  input  logic pol_high_i,
  input  logic push_pull_i,
  input  logic hold_i,
  output logic fall_o,
  output logic irq_o,
  output logic irq_oe
);
  logic src_w, src_q;
  logic asrt_d, asrt_q;

  assign src_w  = pin_en_i & master_i & ~hold_i;
  assign asrt_d = src_w | (pin_en_i & pme_i);
  assign fall_o = src_q & ~src_w & ~hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      asrt_q <= 1'b0;
    end else begin
      src_q  <= src_w;
      asrt_q <= asrt_d;
    end
  end

  always_comb begin
    if (push_pull_i) begin
      irq_oe = 1'b1;
      irq_o  = pol_high_i ? asrt_q : ~asrt_q;
    end else begin
      irq_oe = asrt_q;
      irq_o  = 1'b0;
    end
  end

  // R6: during holdoff without a wake request the pin stays deasserted
  p_hold_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !pme_i) |=> !asrt_q);

  // R3: pin disabled means deasserted next cycle
  p_pin_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en_i |=> !asrt_q);

  // R11: wake input bypasses the holdoff
  p_pme_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_i && pin_en_i) |=> asrt_q);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_US = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] int_sts,
  input  logic [NUM_SRC-1:0] int_en,
  input  logic               pme_irq,
  output logic               irq_o,
  output logic               irq_oe
);
  localparam int TICK_RAW = CLK_HZ / (1_000_000 / TICK_US);
  localparam int TICK_DIV = (TICK_RAW < 1) ? 1 : TICK_RAW;

  pin_cfg_t          cfg;
  logic [INTV_W-1:0] intv_nxt;
  logic              restart;
  logic              wr;
  logic              master;
  logic              hold;
  logic              fall;
  logic              unused_wbits;

  assign wr     = reg_sel & reg_we;
  assign master = |(int_sts & int_en);
  assign unused_wbits = ^{reg_wdata[23:15], reg_wdata[13:9], reg_wdata[7:5], reg_wdata[3:1]};

  irq_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr),
    .wdata_i    (reg_wdata),
    .cfg_o      (cfg),
    .intv_nxt_o (intv_nxt),
    .restart_o  (restart)
  );

  irq_holdoff_timer #(.TICK_DIV(TICK_DIV), .CNT_W(INTV_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .intv_nxt_i  (intv_nxt),
    .start_req_i (restart | fall),
    .active_o    (hold)
  );

  irq_pin_drive u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_i    (master),
    .pme_i       (pme_irq),
    .pin_en_i    (cfg.pin_en),
    .pol_high_i  (cfg.pol_high),
    .push_pull_i (cfg.push_pull),
    .hold_i      (hold),
    .fall_o      (fall),
    .irq_o       (irq_o),
    .irq_oe      (irq_oe)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[INTV_LSB +: INTV_W] = cfg.intv;
      reg_rdata[HOLD_BIT]           = hold;
      reg_rdata[MST_BIT]            = master;
      reg_rdata[EN_BIT]             = cfg.pin_en;
      reg_rdata[POL_BIT]            = cfg.pol_high;
      reg_rdata[TYPE_BIT]           = cfg.push_pull;
    end
  end

  // R5: open-drain mode never drives the line high
  p_od_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.push_pull && irq_oe) |-> !irq_o);
endmodule

// File: tb/tb_irq_pin_ctrl.sv
module tb_irq_pin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int CLK_HZ = 400_000;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_sel, reg_we, pme_irq;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NSRC-1:0] int_sts, int_en;
  logic irq_o, irq_oe;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  irq_pin_ctrl #(.NUM_SRC(NSRC), .CLK_HZ(CLK_HZ), .TICK_US(10)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_sts(int_sts),
    .int_en(int_en), .pme_irq(pme_irq), .irq_o(irq_o), .irq_oe(irq_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [7:0] m_int;
  logic m_en, m_pol, m_pp, m_gprev, m_asrt;
  int m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_int = 0; m_en = 0; m_pol = 0; m_pp = 0;
      m_gprev = 0; m_asrt = 0; m_hold = 0;
    end else begin
      logic mst, g, fs, wr;
      logic [7:0] nint;
      mst  = |(int_sts & int_en);
      g    = m_en && mst && (m_hold == 0);
      fs   = m_gprev && !g && (m_hold == 0);
      wr   = reg_sel && reg_we;
      nint = wr ? reg_wdata[31:24] : m_int;
      m_asrt = g || (m_en && pme_irq);
      m_gprev = g;
      if (nint == 0) m_hold = 0;
      else if ((wr && reg_wdata[14]) || fs) m_hold = nint * DIV;
      else if (m_hold > 0) m_hold = m_hold - 1;
      if (wr) begin
        m_int = reg_wdata[31:24]; m_en = reg_wdata[8];
        m_pol = reg_wdata[4]; m_pp = reg_wdata[0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic mst;
      logic [31:0] ew;
      logic eo, eoe;
      mst = |(int_sts & int_en);
      ew = 32'h0;
      if (reg_sel) ew = {m_int, 10'b0, (m_hold > 0), mst, 3'b0, m_en, 3'b0, m_pol, 3'b0, m_pp};
      chk("R12 word fields", {reg_rdata[31:14], 1'b0, reg_rdata[11:0] & 12'hEFF}, {ew[31:14], 1'b0, ew[11:0] & 12'hEFF});
      chk("R6 holdoff status", {31'b0, reg_rdata[13]}, {31'b0, ew[13]});
      chk("R2 master bit", {31'b0, reg_rdata[12]}, {31'b0, ew[12]});
      if (m_pp) begin eoe = 1'b1; eo = m_pol ? m_asrt : !m_asrt; end
      else begin eoe = m_asrt; eo = 1'b0; end
      if (!m_en)     chk("R3 pin disabled", {30'b0, irq_oe, irq_o}, {30'b0, eoe, eo});
      else if (m_pp) chk("R4 push-pull pin", {30'b0, irq_oe, irq_o}, {30'b0, eoe, eo});
      else           chk("R5 open-drain pin", {30'b0, irq_oe, irq_o}, {30'b0, eoe, eo});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 50000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_hold_end;
    while (reg_rdata[13]) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 1'b1; reg_we = 1'b0; reg_wdata = '0;
    int_sts = '0; int_en = '0; pme_irq = 1'b0;
    step(3);
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset oe", {31'b0, irq_oe}, 32'h0);
    rst_n = 1'b1;
    step(1);

    // push-pull, active high, enabled, no holdoff
    wr(32'h0000_0111);
    int_sts = 8'h05; int_en = 8'h04;
    step(1);
    chk("R4 active high asserted", {31'b0, irq_o}, 32'h1);
    chk("R2 master set", {31'b0, reg_rdata[12]}, 32'h1);
    wr(32'h0000_0101);
    chk("R4 active low asserted", {31'b0, irq_o}, 32'h0);
    wr(32'h0000_0011);
    step(1);
    chk("R3 pin off", {31'b0, irq_o}, 32'h0);
    chk("R3 master still set", {31'b0, reg_rdata[12]}, 32'h1);

    // open-drain, polarity bit set but ignored
    wr(32'h0000_0110);
    step(1);
    chk("R5 od asserted", {30'b0, irq_oe, irq_o}, 32'h2);
    int_en = 8'h00;
    step(2);
    chk("R5 od released", {30'b0, irq_oe, irq_o}, 32'h0);

    // holdoff of 3 ticks
    wr(32'h0300_0111);
    int_en = 8'h04;
    step(2);
    int_en = 8'h00;
    step(1);
    chk("R6 holdoff running", {31'b0, reg_rdata[13]}, 32'h1);
    int_en = 8'h04;
    step(3);
    chk("R6 pin held off", {31'b0, irq_o}, 32'h0);
    wait_hold_end;
    step(1);
    chk("R7 held interrupt delivered", {31'b0, irq_o}, 32'h1);

    // rewrite interval during holdoff
    int_en = 8'h00;
    step(2);
    wr(32'h0100_0111);
    step(4);
    chk("R10 running interval kept", {31'b0, reg_rdata[13]}, 32'h1);
    pme_irq = 1'b1;
    step(1);
    chk("R11 wake bypass", {31'b0, irq_o}, 32'h1);
    pme_irq = 1'b0;
    wait_hold_end;

    // restart by clear bit
    wr(32'h0300_0111);
    int_en = 8'h04;
    step(2);
    int_en = 8'h00;
    step(6);
    wr(32'h0300_4111);
    chk("R9 clear bit reads zero", {31'b0, reg_rdata[14]}, 32'h0);
    step(10);
    chk("R9 fresh interval", {31'b0, reg_rdata[13]}, 32'h1);

    // zero interval while pending
    int_en = 8'h04;
    step(1);
    wr(32'h0000_0111);
    chk("R8 holdoff disabled", {31'b0, reg_rdata[13]}, 32'h0);
    step(1);
    chk("R8 pending issued", {31'b0, irq_o}, 32'h1);

    // reserved bits and select
    wr(32'hFFFF_FFFF);
    chk("R12 reserved zero", reg_rdata & 32'h00FF_CEEE, 32'h0);
    reg_sel = 1'b0;
    wr(32'h0000_0000);
    chk("R12 unselected read", reg_rdata, 32'h0);
    reg_sel = 1'b1;
    step(1);
    chk("R12 unselected write ignored", {24'b0, reg_rdata[31:24]}, 32'hFF);
    wr(32'h0000_0000);
    step(3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule